// File: doc/BRIEF.md
# Classifier Lookup Cycle Sequencer

This block runs the repeating decision loop of a hardware rule classifier. At the start of each lookup it latches a monitor word and a reward value. It then walks every rule of an external rule memory, giving each rule a read slot and then a write slot. It keeps the rules whose ternary condition matches the latched monitor word, picks one of them by fitness-weighted random selection, and issues that rule's action with a one-cycle strobe. It then waits an action-dependent number of cycles before it starts the next lookup.

Learning happens during the traversal. The rule chosen in one lookup has its fitness moved towards the reward latched at the start of the following lookup, so every action has exactly one action delay to show its effect. The new fitness is written in the write slot of that rule's visit. Every other rule word is written back unchanged, so the memory access pattern never varies. The wait after each action comes from a small table of cycle counts indexed by the low bits of the action code. When no rule matched, a separate default count is used. The table and the default count are loaded through a configuration write port.

Top module: `lct_cycle_seq`

## Requirements
- R1: In the first cycle with `rst` low, `cyc_start` is 1 and `act_stb`, `mem_rd` and `mem_we` are 0.
- R2: After each `cyc_start` cycle, rules 0 to N_RULES-1 are visited in ascending order. Each visit is one cycle with `mem_rd`=1 at that address, followed by one cycle with `mem_we`=1 at the same address. Read data returns one cycle after `mem_rd`. The action slot comes in the cycle after the last write, 2*N_RULES+1 cycles after `cyc_start`.
- R3: A rule word holds the care mask in bits [35:28], the condition in [27:20], the action in [19:12] and the fitness in [11:0]. A rule matches when the latched monitor word equals the condition on every bit where the care mask is 1.
- R4: The first matching rule of a traversal is always taken. A later matching rule with fitness F replaces the current choice when (rnd*S)>>16 < F, where S is the matched fitness sum including F. So a later match with fitness 0 never replaces the choice, and a later match whose fitness is the whole sum always does. Selection uses the fitness as written back.
- R5: In the action slot `act_stb` is 1 for exactly one cycle, with `act_out` holding the chosen rule's action. If no rule matched, `act_stb` stays 0.
- R6: After a strobe, the next `cyc_start` comes D+1 cycles after the action slot. D is the delay-table entry indexed by the low DIDX_W bits of the action. When D=0, the next cycle is `cyc_start`.
- R7: After a lookup with no match, the default delay register gives D in the same way.
- R8: A `cfg_we` cycle with `cfg_addr[DIDX_W]`=0 writes table entry `cfg_addr[DIDX_W-1:0]`. With that bit at 1, it writes the default delay register. Reset sets every entry and the default register to RST_DELAY.
- R9: The rule chosen in lookup k gets its fitness written during lookup k+1 as F + ((R-F)>>>3), clamped to 0..4095. R is the reward latched at the start of lookup k+1.
- R10: The care, condition and action fields are always written back unchanged. Every word other than the one being updated is written back unchanged. In the first lookup after reset, and in the lookup after a lookup with no match, all words are written back unchanged.
- R11: `mon_in` and `reward_in` are taken only in the `cyc_start` cycle. Changes during a traversal have no effect on the choice or on the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mon_in | input | 8 | Thresholded monitor word |
| reward_in | input | 12 | Reward for the previous action |
| cyc_start | output | 1 | High in the cycle the inputs are latched |
| act_stb | output | 1 | One-cycle action strobe |
| act_out | output | 8 | Action code of the chosen rule |
| mem_addr | output | 3 | Rule memory address |
| mem_rd | output | 1 | Rule memory read enable |
| mem_rdata | input | 36 | Rule word, one cycle after read |
| mem_we | output | 1 | Rule memory write enable |
| mem_wdata | output | 36 | Rule word written back |
| cfg_we | input | 1 | Delay configuration write enable |
| cfg_addr | input | 3 | Table entry select; MSB selects default register |
| cfg_data | input | 16 | Delay in cycles |

## Verification
The selection is tried with a single matching rule, with a masked partial match, with several matches where only one has nonzero fitness, with several zero-fitness matches, and with two equally fit matches. These patterns separate first-match capture, replacement by a rule holding the whole sum, rejection of zero fitness, and a genuinely random draw. Reward sequences that raise and then lower a fitness, with the choice moving from one rule to another between lookups, show that the write lands one lookup late and on the right rule only. Lookups with no match, with a zero delay and with reprogrammed delays separate the table path from the default path. Monitor and reward changes made during a traversal show that only the latched values count.

// File: rtl/lct_pkg.sv
package lct_pkg;

    localparam int MON_W    = 8;
    localparam int ACT_W    = 8;
    localparam int FIT_W    = 12;
    localparam int DLY_W    = 16;
    localparam int STEP_SH  = 3;
    localparam int RND_W    = 16;
    localparam logic [RND_W-1:0] RND_TAPS = 16'hB400;
    localparam int RULE_W   = 2 * MON_W + ACT_W + FIT_W;

    typedef struct packed {
        logic [MON_W-1:0] care;
        logic [MON_W-1:0] cond;
        logic [ACT_W-1:0] act;
        logic [FIT_W-1:0] fit;
    } rule_t;

    typedef enum logic [2:0] {
        ST_SAMPLE,
        ST_READ,
        ST_VISIT,
        ST_ISSUE,
        ST_WAIT
    } phase_e;

    function automatic logic rule_hit(input rule_t r, input logic [MON_W-1:0] mon);
        return ((r.cond ^ mon) & r.care) == '0;
    endfunction

    // Moves the fitness one eighth of the way towards the reward, floor rounding.
    function automatic logic [FIT_W-1:0] fit_step(input logic [FIT_W-1:0] old_f,
                                                  input logic [FIT_W-1:0] rew);
        logic signed [FIT_W+1:0] diff;
        logic signed [FIT_W+1:0] nxt;
        diff = $signed({2'b00, rew}) - $signed({2'b00, old_f});
        nxt  = $signed({2'b00, old_f}) + (diff >>> STEP_SH);
        if (nxt[FIT_W+1]) return '0;
        if (nxt[FIT_W])   return '1;
        return nxt[FIT_W-1:0];
    endfunction

endpackage

// File: rtl/lct_lfsr.sv
module lct_lfsr #(
    parameter int               W    = 16,
    parameter logic [W-1:0]     TAPS = 16'hB400,
    parameter logic [W-1:0]     SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] rnd
);
    logic [W-1:0] state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEED;
        end else if (state[0]) begin
            state <= (state >> 1) ^ TAPS;
        end else begin
            state <= state >> 1;
        end
    end

    assign rnd = state;
endmodule

// File: rtl/lct_pick.sv
module lct_pick
    import lct_pkg::*;
#(
    parameter int AW = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             visit,
    input  logic             hit,
    input  logic [FIT_W-1:0] fit,
    input  logic [ACT_W-1:0] act,
    input  logic [AW-1:0]    idx,
    input  logic [RND_W-1:0] rnd,
    output logic             sel_valid,
    output logic [ACT_W-1:0] sel_act,
    output logic [AW-1:0]    sel_idx
);
    localparam int SUM_W  = FIT_W + AW;
    localparam int PROD_W = SUM_W + RND_W;

    logic [SUM_W-1:0]  sum_q;
    logic [SUM_W-1:0]  sum_n;
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] scaled;
    logic              take;

    // Reservoir of one: the newcomer wins with probability fit / running sum.
    always_comb begin
        sum_n  = sum_q + SUM_W'(fit);
        prod   = PROD_W'(rnd) * PROD_W'(sum_n);
        scaled = prod >> RND_W;
        take   = !sel_valid || (scaled < PROD_W'(fit));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q     <= '0;
            sel_valid <= 1'b0;
            sel_act   <= '0;
            sel_idx   <= '0;
        end else if (clear) begin
            sum_q     <= '0;
            sel_valid <= 1'b0;
        end else if (visit && hit) begin
            sum_q <= sum_n;
            if (take) begin
                sel_valid <= 1'b1;
                sel_act   <= act;
                sel_idx   <= idx;
            end
        end
    end
endmodule

// File: rtl/lct_dly_tab.sv
module lct_dly_tab
    import lct_pkg::*;
#(
    parameter int DIDX_W    = 2,
    parameter int RST_DELAY = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [DIDX_W:0]   cfg_addr,
    input  logic [DLY_W-1:0]  cfg_data,
    input  logic [DIDX_W-1:0] act_idx,
    input  logic              use_dflt,
    output logic [DLY_W-1:0]  dly
);
    localparam int ENT = 1 << DIDX_W;

    logic [DLY_W-1:0] tab [ENT];
    logic [DLY_W-1:0] dflt;

    for (genvar g = 0; g < ENT; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                tab[g] <= DLY_W'(RST_DELAY);
            end else if (cfg_we && !cfg_addr[DIDX_W] && cfg_addr[DIDX_W-1:0] == DIDX_W'(g)) begin
                tab[g] <= cfg_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dflt <= DLY_W'(RST_DELAY);
        end else if (cfg_we && cfg_addr[DIDX_W]) begin
            dflt <= cfg_data;
        end
    end

    assign dly = use_dflt ? dflt : tab[act_idx];
endmodule

// File: rtl/lct_cycle_seq.sv
module lct_cycle_seq
    import lct_pkg::*;
#(
    parameter int               N_RULES   = 8,
    parameter int               DIDX_W    = 2,
    parameter int               RST_DELAY = 4,
    parameter logic [RND_W-1:0] RND_SEED  = 16'hACE1,
    localparam int              AW        = $clog2(N_RULES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MON_W-1:0]  mon_in,
    input  logic [FIT_W-1:0]  reward_in,
    output logic              cyc_start,
    output logic              act_stb,
    output logic [ACT_W-1:0]  act_out,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_rd,
    input  logic [RULE_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic [RULE_W-1:0] mem_wdata,
    input  logic              cfg_we,
    input  logic [DIDX_W:0]   cfg_addr,
    input  logic [DLY_W-1:0]  cfg_data
);
    phase_e           phase;
    logic [AW-1:0]    idx;
    logic [MON_W-1:0] mon_q;
    logic [FIT_W-1:0] rew_q;
    logic             upd_pend;
    logic [AW-1:0]    upd_idx;
    logic [DLY_W-1:0] wait_cnt;

    rule_t            rd_rule;
    rule_t            wr_rule;
    logic             visit;
    logic             hit;
    logic             last;
    logic [RND_W-1:0] rnd;
    logic             sel_valid;
    logic [ACT_W-1:0] sel_act;
    logic [AW-1:0]    sel_idx;
    logic [DLY_W-1:0] dly;

    assign visit   = (phase == ST_VISIT);
    assign rd_rule = rule_t'(mem_rdata);
    assign hit     = rule_hit(rd_rule, mon_q);
    assign last    = (idx == AW'(N_RULES - 1));

    // Deferred reward: only the previous winner's word gets a new fitness.
    always_comb begin
        wr_rule = rd_rule;
        if (upd_pend && idx == upd_idx) begin
            wr_rule.fit = fit_step(rd_rule.fit, rew_q);
        end
    end

    lct_lfsr #(
        .W    (RND_W),
        .TAPS (RND_TAPS),
        .SEED (RND_SEED)
    ) u_lfsr (
        .clk (clk),
        .rst (rst),
        .rnd (rnd)
    );

    lct_pick #(
        .AW (AW)
    ) u_pick (
        .clk       (clk),
        .rst       (rst),
        .clear     (phase == ST_SAMPLE),
        .visit     (visit),
        .hit       (hit),
        .fit       (wr_rule.fit),
        .act       (rd_rule.act),
        .idx       (idx),
        .rnd       (rnd),
        .sel_valid (sel_valid),
        .sel_act   (sel_act),
        .sel_idx   (sel_idx)
    );

    lct_dly_tab #(
        .DIDX_W    (DIDX_W),
        .RST_DELAY (RST_DELAY)
    ) u_dly (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_data (cfg_data),
        .act_idx  (sel_act[DIDX_W-1:0]),
        .use_dflt (!sel_valid),
        .dly      (dly)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= ST_SAMPLE;
            idx      <= '0;
            mon_q    <= '0;
            rew_q    <= '0;
            upd_pend <= 1'b0;
            upd_idx  <= '0;
            wait_cnt <= '0;
        end else begin
            case (phase)
                ST_SAMPLE: begin
                    mon_q <= mon_in;
                    rew_q <= reward_in;
                    idx   <= '0;
                    phase <= ST_READ;
                end
                ST_READ: begin
                    phase <= ST_VISIT;
                end
                ST_VISIT: begin
                    if (last) begin
                        phase <= ST_ISSUE;
                    end else begin
                        idx   <= idx + 1'b1;
                        phase <= ST_READ;
                    end
                end
                ST_ISSUE: begin
                    upd_pend <= sel_valid;
                    upd_idx  <= sel_idx;
                    if (dly == '0) begin
                        phase <= ST_SAMPLE;
                    end else begin
                        wait_cnt <= dly;
                        phase    <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (wait_cnt <= DLY_W'(1)) begin
                        phase <= ST_SAMPLE;
                    end else begin
                        wait_cnt <= wait_cnt - 1'b1;
                    end
                end
                default: phase <= ST_SAMPLE;
            endcase
        end
    end

    assign cyc_start = (phase == ST_SAMPLE);
    assign act_stb   = (phase == ST_ISSUE) && sel_valid;
    assign act_out   = sel_act;
    assign mem_addr  = idx;
    assign mem_rd    = (phase == ST_READ);
    assign mem_we    = visit;
    assign mem_wdata = wr_rule;
endmodule

// File: rtl/lct_cycle_seq_chk.sv
module lct_cycle_seq_chk
    import lct_pkg::*;
#(
    parameter int N_RULES = 8,
    parameter int AW      = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              cyc_start,
    input logic              act_stb,
    input logic [AW-1:0]     mem_addr,
    input logic              mem_rd,
    input logic [RULE_W-1:0] mem_rdata,
    input logic              mem_we,
    input logic [RULE_W-1:0] mem_wdata,
    input logic              upd_pend,
    input logic [AW-1:0]     upd_idx
);
    assert_rd_we_excl_R2: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_we));

    assert_write_after_read_R2: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> ($past(mem_rd) && mem_addr == $past(mem_addr)));

    assert_start_reads_first_R2: assert property (@(posedge clk) disable iff (rst)
        cyc_start |=> (mem_rd && mem_addr == '0));

    assert_strobe_after_last_R2: assert property (@(posedge clk) disable iff (rst)
        act_stb |-> ($past(mem_we) && $past(mem_addr) == AW'(N_RULES - 1)));

    assert_strobe_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        act_stb |=> !act_stb);

    assert_fields_kept_R10: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_wdata[RULE_W-1:FIT_W] == mem_rdata[RULE_W-1:FIT_W]));

    assert_only_target_changes_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_we && !(upd_pend && mem_addr == upd_idx)) |-> (mem_wdata == mem_rdata));
endmodule

bind lct_cycle_seq lct_cycle_seq_chk #(
    .N_RULES (N_RULES),
    .AW      (AW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cyc_start (cyc_start),
    .act_stb   (act_stb),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_rdata (mem_rdata),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .upd_pend  (upd_pend),
    .upd_idx   (upd_idx)
);

// File: tb/sim_lct_cycle_seq.sv
`timescale 1ns/1ps
module sim_lct_cycle_seq;
    import lct_pkg::*;

    localparam int N  = 8;
    localparam int AW = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [MON_W-1:0]  mon_in = '0;
    logic [FIT_W-1:0]  reward_in = '0;
    logic              cyc_start, act_stb, mem_rd, mem_we;
    logic [ACT_W-1:0]  act_out;
    logic [AW-1:0]     mem_addr;
    logic [RULE_W-1:0] mem_rdata = '0;
    logic [RULE_W-1:0] mem_wdata;
    logic              cfg_we = 1'b0;
    logic [2:0]        cfg_addr = '0;
    logic [DLY_W-1:0]  cfg_data = '0;

    logic              ld_en = 1'b0;
    logic [AW-1:0]     ld_addr = '0;
    logic [RULE_W-1:0] ld_data = '0;
    logic [RULE_W-1:0] mem [N];
    logic [RULE_W-1:0] rules [N];
    logic [RULE_W-1:0] wr_seen [N];

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    int pend_n = 0;
    logic [2:0]       pend_addr [4];
    logic [DLY_W-1:0] pend_data [4];
    logic             got_stb;
    logic [ACT_W-1:0] got_act;

    always #5 clk = ~clk;

    lct_cycle_seq u0 (
        .clk (clk), .rst (rst), .mon_in (mon_in), .reward_in (reward_in),
        .cyc_start (cyc_start), .act_stb (act_stb), .act_out (act_out),
        .mem_addr (mem_addr), .mem_rd (mem_rd), .mem_rdata (mem_rdata),
        .mem_we (mem_we), .mem_wdata (mem_wdata),
        .cfg_we (cfg_we), .cfg_addr (cfg_addr), .cfg_data (cfg_data)
    );

    // Rule memory model: one-cycle read latency, bench load port used during reset.
    always @(posedge clk) begin
        if (ld_en) mem[ld_addr] <= ld_data;
        if (mem_rd) mem_rdata <= mem[mem_addr];
        if (mem_we) mem[mem_addr] <= mem_wdata;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000) begin
            nfail = nfail + 1;
            $display("FAIL watchdog: run did not finish, got %0d cycles expected below 50000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    function automatic logic [RULE_W-1:0] mk(input logic [7:0] care, input logic [7:0] cond,
                                             input logic [7:0] act, input int fit);
        return {care, cond, act, 12'(fit)};
    endfunction

    function automatic int step(input int old_f, input int rew);
        int n;
        n = old_f + ((rew - old_f) >>> 3);
        if (n < 0) n = 0;
        if (n > 4095) n = 4095;
        return n;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint got, input longint exp);
        nchk = nchk + 1;
        if (!ok) begin
            nfail = nfail + 1;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    // Non-matching filler: care all ones, condition 0xEE.
    task automatic fill_default();
        for (int i = 0; i < N; i++) rules[i] = mk(8'hFF, 8'hEE, 8'(8'hE0 + i), 5);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            ld_en = 1'b1; ld_addr = AW'(i); ld_data = rules[i];
        end
        @(negedge clk);
        ld_en = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(cyc_start == 1'b1, "R1", "cyc_start after reset", cyc_start, 1);
        chk(act_stb == 1'b0 && mem_rd == 1'b0 && mem_we == 1'b0, "R1", "idle outputs after reset",
            {act_stb, mem_rd, mem_we}, 0);
    endtask

    // Called in a cyc_start cycle; returns in the next cyc_start cycle.
    task automatic run_lookup(input logic [7:0] mv, input int rv, input logic [7:0] mm, input int rm,
                              input bit es, input bit ca, input logic [7:0] ea, input int eg,
                              input string tg);
        bit ok;
        int gap;
        ok = 1'b1;
        mon_in = mv; reward_in = 12'(rv);
        for (int c = 1; c <= 2 * N; c++) begin
            @(negedge clk);
            if (c == 1) begin mon_in = mm; reward_in = 12'(rm); end
            if (c <= pend_n) begin
                cfg_we = 1'b1; cfg_addr = pend_addr[c-1]; cfg_data = pend_data[c-1];
            end else begin
                cfg_we = 1'b0;
            end
            if (c % 2 == 1) begin
                if (!(mem_rd && !mem_we && mem_addr == AW'((c - 1) / 2))) ok = 1'b0;
            end else begin
                if (!(mem_we && !mem_rd && mem_addr == AW'(c / 2 - 1))) ok = 1'b0;
                wr_seen[c / 2 - 1] = mem_wdata;
            end
            if (act_stb || cyc_start) ok = 1'b0;
        end
        pend_n = 0;
        chk(ok, "R2", {tg, " visit order"}, ok, 1);
        @(negedge clk);
        got_stb = act_stb; got_act = act_out;
        chk(got_stb == es, "R5", {tg, " strobe"}, got_stb, es);
        if (es && ca) chk(got_act == ea, "R5", {tg, " action"}, got_act, ea);
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
            if (act_stb) ok = 1'b0;
        end while (!cyc_start && gap < 1000);
        chk(gap == eg, "R6", {tg, " gap to next start"}, gap, eg);
        #1;
    endtask

    task automatic t_single();
        int ok;
        fill_default();
        rules[3] = mk(8'hFF, 8'h5A, 8'h21, 100);
        do_reset();
        run_lookup(8'h5A, 0, 8'h5A, 0, 1, 1, 8'h21, 5, "single1");
        ok = 1;
        for (int i = 0; i < N; i++) if (wr_seen[i] != rules[i]) ok = 0;
        chk(ok == 1, "R10", "first lookup writes unchanged", ok, 1);
        run_lookup(8'h5A, 900, 8'h5A, 900, 1, 1, 8'h21, 5, "single2");
        chk(wr_seen[3] == mk(8'hFF, 8'h5A, 8'h21, step(100, 900)), "R9", "raised fitness",
            wr_seen[3], mk(8'hFF, 8'h5A, 8'h21, step(100, 900)));
        ok = 1;
        for (int i = 0; i < N; i++) if (i != 3 && wr_seen[i] != rules[i]) ok = 0;
        chk(ok == 1, "R10", "other words unchanged", ok, 1);
        run_lookup(8'h5A, 0, 8'h5A, 0, 1, 1, 8'h21, 5, "single3");
        chk(wr_seen[3][11:0] == 12'(step(200, 0)), "R9", "lowered fitness", wr_seen[3][11:0], step(200, 0));
    endtask

    task automatic t_mask();
        fill_default();
        rules[0] = mk(8'h0F, 8'h05, 8'h40, 0);
        rules[2] = mk(8'hF0, 8'hA0, 8'h42, 50);
        rules[5] = mk(8'h80, 8'h00, 8'h45, 0);
        do_reset();
        run_lookup(8'hA7, 0, 8'hA7, 0, 1, 1, 8'h42, 5, "R3 masked match");
    endtask

    task automatic t_select();
        fill_default();
        rules[1] = mk(8'h00, 8'h00, 8'h11, 0);
        rules[4] = mk(8'h00, 8'h00, 8'h14, 300);
        rules[6] = mk(8'h00, 8'h00, 8'h16, 0);
        do_reset();
        run_lookup(8'h33, 0, 8'h33, 0, 1, 1, 8'h14, 5, "R4 whole-sum winner");
        fill_default();
        rules[2] = mk(8'h00, 8'h00, 8'h12, 0);
        rules[5] = mk(8'h00, 8'h00, 8'h15, 0);
        do_reset();
        run_lookup(8'h33, 0, 8'h33, 0, 1, 1, 8'h12, 5, "R4 zero fitness keeps first");
        fill_default();
        rules[1] = mk(8'h00, 8'h00, 8'h31, 1000);
        rules[5] = mk(8'h00, 8'h00, 8'h35, 1000);
        do_reset();
        run_lookup(8'h33, 0, 8'h33, 0, 1, 0, 8'h00, 5, "R4 random");
        chk(got_act == 8'h31 || got_act == 8'h35, "R4", "random pick among matches", got_act, 8'h31);
    endtask

    task automatic t_nomatch();
        int ok;
        fill_default();
        rules[6] = mk(8'hFF, 8'h77, 8'h0A, 40);
        do_reset();
        pend_addr[0] = 3'b100; pend_data[0] = 16'd7;
        pend_addr[1] = 3'b010; pend_data[1] = 16'd0;
        pend_n = 2;
        run_lookup(8'h01, 0, 8'h01, 0, 0, 0, 8'h00, 8, "R7 default delay");
        run_lookup(8'h77, 4000, 8'h77, 4000, 1, 1, 8'h0A, 1, "R8 zero table delay");
        ok = 1;
        for (int i = 0; i < N; i++) if (wr_seen[i] != rules[i]) ok = 0;
        chk(ok == 1, "R10", "no update after no-match lookup", ok, 1);
        run_lookup(8'h01, 4000, 8'h01, 4000, 0, 0, 8'h00, 8, "R5 no match");
        chk(wr_seen[6][11:0] == 12'(step(40, 4000)), "R9", "update after match",
            wr_seen[6][11:0], step(40, 4000));
    endtask

    task automatic t_sampled();
        fill_default();
        rules[2] = mk(8'hFF, 8'h10, 8'h22, 64);
        rules[7] = mk(8'hFF, 8'h20, 8'h27, 64);
        do_reset();
        run_lookup(8'h10, 0, 8'h20, 0, 1, 1, 8'h22, 5, "R11 monitor latched");
        run_lookup(8'h20, 800, 8'h10, 0, 1, 1, 8'h27, 5, "R11 second");
        chk(wr_seen[2][11:0] == 12'(step(64, 800)), "R11", "reward latched at start",
            wr_seen[2][11:0], step(64, 800));
        chk(wr_seen[7] == rules[7], "R9", "new winner not yet updated", wr_seen[7], rules[7]);
        run_lookup(8'h20, 0, 8'h20, 0, 1, 1, 8'h27, 5, "R9 third");
        chk(wr_seen[7][11:0] == 12'(step(64, 0)), "R9", "one-lookup deferral",
            wr_seen[7][11:0], step(64, 0));
        chk(wr_seen[2][11:0] == 12'(step(64, 800)), "R10", "earlier winner kept",
            wr_seen[2][11:0], step(64, 800));
    endtask

    initial begin
        t_single();
        t_mask();
        t_select();
        t_nomatch();
        t_sampled();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule